// File: doc/BRIEF.md
# Single-Wire Return-to-One Host Master

This block is the host end of a one-wire serial link that uses timed low-then-high bit frames on an open-drain line with an external pull-up. The master never drives the line high. It either pulls the line low or lets go of it, and the line rests high when idle. Every transaction opens with a break: a long low interval followed by a high recovery interval. After the break the master sends one command byte. The top bit of the command picks the direction. When that bit is 1, the master sends one more data byte. When it is 0, the peripheral drives back eight bits, which the master collects.

On the system side a transaction is launched with a one-cycle `start_i` pulse, which captures the command and write-data inputs. `busy_o` stays high until the one-cycle `done_o` pulse. Read results appear on `rdata_o` and stay there. On the pad side, `drive_low_o` enables a pull-down and `line_i` is the raw line level; the block resynchronises `line_i` through two flops. All intervals are parameters counted in system clocks. The frame parameter must cover at least 3 ms, which keeps the rate at or below 333 bit/s. The intervals must also satisfy START_CYC < SAMPLE_CYC < HOLD_CYC < STOP_CYC-3 < FRAME_CYC.

Top module: `rto_host_master`

## Requirements
- R1: After reset the outputs are: `busy_o`=0, `done_o`=0, `timeout_o`=0, `drive_low_o`=0 and `rdata_o`=00h.
- R2: An accepted start produces a break. `drive_low_o` is high for exactly BREAK_CYC cycles from the cycle in which `busy_o` rises. It is then low for RECOV_CYC+1 cycles before the first bit frame.
- R3: Each bit frame begins with the master pulling low. A transmitted 1 is held low for START_CYC cycles and a transmitted 0 for HOLD_CYC cycles. Successive frame falling edges are exactly FRAME_CYC+1 cycles apart.
- R4: Bytes go on the wire least-significant bit first. Command 03h appears as 1,1,0,0,0,0,0,0.
- R5: A command with bit 7 = 1 is a write. After the command byte comes one more byte, `wdata_i`, least-significant bit first. Bits 6:0 of the command name the peripheral register.
- R6: A command with bit 7 = 0 is a read. For each of the eight following frames the master pulls low for START_CYC cycles only. It samples the synchronised line SAMPLE_CYC cycles after its own falling edge and assembles the bits least-significant first. Returned bits 1,0,1,0,0,1,1,0 give `rdata_o`=65h.
- R7: `rdata_o` changes only when a read transaction completes. A write transaction leaves it unchanged.
- R8: `busy_o` is high from the cycle after the start pulse until the end of the transaction. `done_o` is a single-cycle pulse in the first cycle `busy_o` is low. `drive_low_o` is never high while `busy_o` is low.
- R9: A start pulse while `busy_o` is high is ignored. The running transaction keeps its captured command and data.
- R10: If the synchronised line is still low STOP_CYC cycles into a frame, the master does three things: it ends the transaction with `done_o`, sets `timeout_o` and releases the line. `timeout_o` stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a transaction |
| cmd_i | input | 8 | Command byte; bit 7 = write, bits 6:0 = register |
| wdata_i | input | 8 | Data byte for a write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| timeout_o | output | 1 | Last transaction aborted on a stuck-low line |
| rdata_o | output | 8 | Byte returned by the latest read |
| line_i | input | 1 | Raw level of the open-drain line |
| drive_low_o | output | 1 | Pull-down enable for the line pad |

## Verification
The assertions rely on two assumptions about the inputs: `start_i` is a single-cycle pulse, and the peripheral only pulls the line low inside a frame the master has opened. In the second case it releases the line well before the stop deadline, unless a stall is meant. The bench peripheral model behaves this way. It answers read bits by holding the line low from the master's falling edge up to a point between the sample and hold instants. It drives nothing otherwise. The one deliberate stall comes from a separate stuck-low control, used only in the timeout case.

// File: rtl/rto_pkg.sv
package rto_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BRK,
    S_REC,
    S_CMD,
    S_DAT
  } seq_state_t;

  // Pull-down decision inside one bit frame.
  function automatic logic frame_pulls_low(input logic rd, input logic bval,
                                           input logic in_start, input logic in_hold);
    return in_start || (!rd && !bval && in_hold);
  endfunction

  // Receive assembly: first bit lands in bit 0 after eight shifts.
  function automatic logic [7:0] shift_lsb_first(input logic [7:0] acc, input logic b);
    return {b, acc[7:1]};
  endfunction

  function automatic logic cmd_is_write(input logic [7:0] c);
    return c[7];
  endfunction

endpackage

// File: rtl/rto_sync.sv
module rto_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rto_bit_engine.sv
module rto_bit_engine
  import rto_pkg::*;
#(
  parameter int START_CYC  = 60,
  parameter int SAMPLE_CYC = 250,
  parameter int HOLD_CYC   = 400,
  parameter int STOP_CYC   = 700,
  parameter int FRAME_CYC  = 3300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic rd_i,
  input  logic bit_i,
  input  logic line_s_i,
  output logic active_o,
  output logic drive_low_o,
  output logic sample_o,
  output logic rx_bit_o,
  output logic frame_end_o,
  output logic timeout_o
);
  localparam int CW = $clog2(FRAME_CYC + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic          bit_q;
  logic          in_start;
  logic          in_hold;

  assign in_start    = cnt < CW'(START_CYC);
  assign in_hold     = cnt < CW'(HOLD_CYC);
  assign drive_low_o = active && frame_pulls_low(rd_q, bit_q, in_start, in_hold);
  assign sample_o    = active && (cnt == CW'(SAMPLE_CYC));
  assign rx_bit_o    = line_s_i;
  assign timeout_o   = active && (cnt == CW'(STOP_CYC)) && !line_s_i;
  assign frame_end_o = active && (cnt == CW'(FRAME_CYC - 1));
  assign active_o    = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      rd_q   <= 1'b0;
      bit_q  <= 1'b0;
    end else if (!active) begin
      if (go_i) begin
        active <= 1'b1;
        cnt    <= '0;
        rd_q   <= rd_i;
        bit_q  <= bit_i;
      end
    end else if (timeout_o || frame_end_o) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_q && !in_start) |-> !drive_low_o);

  // R10
  abort_stops_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !active);
endmodule

// File: rtl/rto_seq.sv
module rto_seq
  import rto_pkg::*;
#(
  parameter int BREAK_CYC = 200,
  parameter int RECOV_CYC = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       eng_active_i,
  input  logic       frame_end_i,
  input  logic       sample_i,
  input  logic       rx_bit_i,
  input  logic       bit_timeout_i,
  output logic       go_o,
  output logic       rd_o,
  output logic       bit_o,
  output logic       brk_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o,
  output logic [7:0] rdata_o
);
  localparam int LONGEST = (BREAK_CYC > RECOV_CYC) ? BREAK_CYC : RECOV_CYC;
  localparam int TW      = $clog2(LONGEST + 1);

  seq_state_t    state;
  logic [TW-1:0] tcnt;
  logic [7:0]    cmd_q;
  logic [7:0]    wd_q;
  logic [2:0]    idx;
  logic [7:0]    acc;
  logic          in_bits;
  logic          is_read;

  assign in_bits   = (state == S_CMD) || (state == S_DAT);
  assign is_read   = !cmd_is_write(cmd_q);
  assign go_o      = in_bits && !eng_active_i;
  assign rd_o      = (state == S_DAT) && is_read;
  assign bit_o     = (state == S_CMD) ? cmd_q[idx] : wd_q[idx];
  assign brk_low_o = (state == S_BRK);
  assign busy_o    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      cmd_q     <= '0;
      wd_q      <= '0;
      idx       <= '0;
      acc       <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          cmd_q     <= cmd_i;
          wd_q      <= wdata_i;
          tcnt      <= '0;
          timeout_o <= 1'b0;
          state     <= S_BRK;
        end
        S_BRK: if (tcnt == TW'(BREAK_CYC - 1)) begin
          tcnt  <= '0;
          state <= S_REC;
        end else tcnt <= tcnt + 1'b1;
        S_REC: if (tcnt == TW'(RECOV_CYC - 1)) begin
          tcnt  <= '0;
          idx   <= '0;
          state <= S_CMD;
        end else tcnt <= tcnt + 1'b1;
        S_CMD, S_DAT: begin
          if (bit_timeout_i) begin
            state     <= S_IDLE;
            done_o    <= 1'b1;
            timeout_o <= 1'b1;
          end else begin
            if (sample_i && rd_o) acc <= shift_lsb_first(acc, rx_bit_i);
            if (frame_end_i) begin
              if (idx == 3'd7) begin
                idx <= '0;
                if (state == S_CMD) state <= S_DAT;
                else begin
                  state  <= S_IDLE;
                  done_o <= 1'b1;
                  if (is_read) rdata_o <= acc;
                end
              end else idx <= idx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(cmd_q));

  // R10
  timeout_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_timeout_i |=> (!busy_o && timeout_o));
endmodule

// File: rtl/rto_host_master.sv
module rto_host_master #(
  parameter int BREAK_CYC  = 200,
  parameter int RECOV_CYC  = 60,
  parameter int START_CYC  = 60,
  parameter int SAMPLE_CYC = 250,
  parameter int HOLD_CYC   = 400,
  parameter int STOP_CYC   = 700,
  parameter int FRAME_CYC  = 3300,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o,
  output logic [7:0] rdata_o,
  input  logic       line_i,
  output logic       drive_low_o
);
  logic line_s;
  logic go, rd, bit_v, brk_low;
  logic eng_active, eng_low, sample, rx_bit, frame_end, bit_timeout;

  rto_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
  );

  rto_bit_engine #(
    .START_CYC(START_CYC), .SAMPLE_CYC(SAMPLE_CYC), .HOLD_CYC(HOLD_CYC),
    .STOP_CYC(STOP_CYC), .FRAME_CYC(FRAME_CYC)
  ) eng_i (
    .clk(clk), .rst_n(rst_n), .go_i(go), .rd_i(rd), .bit_i(bit_v),
    .line_s_i(line_s), .active_o(eng_active), .drive_low_o(eng_low),
    .sample_o(sample), .rx_bit_o(rx_bit), .frame_end_o(frame_end),
    .timeout_o(bit_timeout)
  );

  rto_seq #(.BREAK_CYC(BREAK_CYC), .RECOV_CYC(RECOV_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .wdata_i(wdata_i), .eng_active_i(eng_active), .frame_end_i(frame_end),
    .sample_i(sample), .rx_bit_i(rx_bit), .bit_timeout_i(bit_timeout),
    .go_o(go), .rd_o(rd), .bit_o(bit_v), .brk_low_o(brk_low),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .rdata_o(rdata_o)
  );

  assign drive_low_o = brk_low || eng_low;

  // R8
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !drive_low_o);

  // R2
  break_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> drive_low_o);
endmodule

// File: tb/rto_host_master_tb_top.sv
module rto_host_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_BREAK = 40, P_RECOV = 12, P_START = 4, P_SAMPLE = 12;
  localparam int P_HOLD = 20, P_STOP = 30, P_FRAME = 40;
  localparam int PER_HOLD = 18;   // peripheral release point for a returned 0
  localparam int BRK_SEEN = 30;   // peripheral break threshold

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] cmd_i = '0, wdata_i = '0;
  logic busy_o, done_o, timeout_o, drive_low_o;
  logic [7:0] rdata_o;
  logic dq_line;
  logic periph_low = 1'b0, stuck_low = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dq_line = !drive_low_o && !periph_low && !stuck_low;

  rto_host_master #(
    .BREAK_CYC(P_BREAK), .RECOV_CYC(P_RECOV), .START_CYC(P_START),
    .SAMPLE_CYC(P_SAMPLE), .HOLD_CYC(P_HOLD), .STOP_CYC(P_STOP),
    .FRAME_CYC(P_FRAME)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o), .rdata_o(rdata_o), .line_i(dq_line),
    .drive_low_o(drive_low_o)
  );

  function automatic logic [7:0] init_val(input int a);
    return (a == 3) ? 8'h65 : 8'((a * 29 + 90) & 255);
  endfunction

  function automatic int exp_width(input int k, input logic [7:0] c, input logic [7:0] w);
    if (k == 0) return P_BREAK;
    if (k <= 8) return c[k-1] ? P_START : P_HOLD;
    if (c[7])   return w[k-9] ? P_START : P_HOLD;
    return P_START;
  endfunction

  function automatic int exp_gap(input int k, input logic [7:0] c, input logic [7:0] w);
    if (k == 1) return P_RECOV + 1;
    return P_FRAME + 1 - exp_width(k - 1, c, w);
  endfunction

  // Peripheral model and pulse monitor
  logic [7:0] pregs [0:127];
  logic [7:0] cmd_rx, wr_rx;
  logic [15:0] wire_bits;
  int bitn, ecnt, low_run, lo_cnt, hi_cnt, dp;
  int drv_w [0:23];
  int drv_gap [0:23];
  logic prev_w, d_prev, busy_prev;

  always @(negedge clk) begin
    logic w, d;
    if (!rst_n) begin
      for (int a = 0; a < 128; a++) pregs[a] = init_val(a);
      bitn = 16; ecnt = 999; low_run = 0; prev_w = 1'b1; periph_low = 1'b0;
      cmd_rx = '0; wr_rx = '0; wire_bits = '0;
      lo_cnt = 0; hi_cnt = 0; dp = 0; d_prev = 1'b0; busy_prev = 1'b0;
    end else begin
      w = dq_line;
      if (prev_w && !w) begin
        ecnt = 0;
        if (bitn >= 8 && bitn < 16 && !cmd_rx[7]) begin
          periph_low = !pregs[cmd_rx[6:0]][bitn-8];
          w = dq_line;
        end
      end else if (ecnt < 999) ecnt++;
      if (!prev_w && w && low_run >= BRK_SEEN) bitn = 0;
      low_run = w ? 0 : low_run + 1;
      if (ecnt == PER_HOLD) periph_low = 1'b0;
      if (ecnt == P_SAMPLE && bitn < 16) begin
        wire_bits[bitn] = w;
        if (bitn < 8) cmd_rx[bitn] = w;
        else if (cmd_rx[7]) wr_rx[bitn-8] = w;
        bitn++;
        if (bitn == 16 && cmd_rx[7]) pregs[cmd_rx[6:0]] = wr_rx;
      end
      prev_w = w;
      // host pull-down pulse monitor
      d = drive_low_o;
      if (busy_o && !busy_prev) begin dp = 0; hi_cnt = 0; end
      if (d && !d_prev) begin
        if (dp < 24) drv_gap[dp] = hi_cnt;
        lo_cnt = 1;
      end else if (!d && d_prev) begin
        if (dp < 24) drv_w[dp] = lo_cnt;
        dp++;
        hi_cnt = 1;
      end else if (d) lo_cnt++;
      else hi_cnt++;
      d_prev = d;
      busy_prev = busy_o;
    end
  end

  logic [7:0] mdl [0:127];

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // mode 0: plain, 1: extra start mid-run (R9), 2: stuck-low line (R10)
  task automatic run_txn(input logic [7:0] c, input logic [7:0] w, input int mode,
                         input bit timing);
    logic [7:0] rd_before;
    int it;
    bit seen_done;
    rd_before = rdata_o;
    @(negedge clk);
    start_i = 1'b1; cmd_i = c; wdata_i = w;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8", "busy after start", busy_o, 1);
    chk("R10", "timeout cleared by start", timeout_o, 0);
    it = 0; seen_done = 1'b0;
    while (!seen_done && it < 3000) begin
      @(negedge clk);
      it++;
      start_i = 1'b0;
      if (done_o) seen_done = 1'b1;
      else if (!busy_o) chk("R8", "busy dropped without done", 0, 1);
      if (mode == 1 && it == 200) begin
        start_i = 1'b1; cmd_i = ~c; wdata_i = ~w;
      end
      if (mode == 2 && dp == 3) stuck_low = 1'b1;
    end
    chk("R8", "done seen", seen_done, 1);
    chk("R8", "busy low with done", busy_o, 0);
    if (mode == 2) begin
      chk("R10", "timeout flag", timeout_o, 1);
      chk("R10", "line released", drive_low_o, 0);
      chk("R7", "rdata kept on abort", rdata_o, rd_before);
      repeat (3) @(negedge clk);
      stuck_low = 1'b0;
      repeat (5) @(negedge clk);
      chk("R10", "timeout held", timeout_o, 1);
      return;
    end
    @(negedge clk);
    chk("R8", "done one cycle", done_o, 0);
    chk("R10", "no timeout", timeout_o, 0);
    chk("R4", "command on wire", cmd_rx, c);
    if (c[7]) begin
      chk("R5", "peripheral register written", pregs[c[6:0]], w);
      chk("R7", "rdata unchanged by write", rdata_o, rd_before);
      mdl[c[6:0]] = w;
    end else begin
      chk("R6", "read data", rdata_o, mdl[c[6:0]]);
    end
    if (timing) begin
      chk("R3", "pulse count", dp, 17);
      chk("R2", "break width", drv_w[0], exp_width(0, c, w));
      for (int k = 1; k < 17; k++) begin
        chk(k > 8 && !c[7] ? "R6" : "R3", "pulse width", drv_w[k], exp_width(k, c, w));
        chk(k == 1 ? "R2" : "R3", "gap", drv_gap[k], exp_gap(k, c, w));
      end
    end
  endtask

  initial begin
    for (int a = 0; a < 128; a++) mdl[a] = init_val(a);
    void'($urandom(32'd20250611));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "drive", drive_low_o, 0);
    chk("R1", "timeout", timeout_o, 0);
    chk("R1", "rdata", rdata_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy after release", busy_o, 0);

    // R4 / R6 directed: read register 3, returns 65h
    run_txn(8'h03, 8'h00, 0, 1'b1);
    chk("R4", "03h wire bits", wire_bits[7:0], 8'b0000_0011);
    chk("R6", "65h wire bits", wire_bits[15:8], 8'h65);
    chk("R6", "65h result", rdata_o, 8'h65);
    // R5 directed edge values
    run_txn(8'hFF, 8'h00, 0, 1'b1);
    run_txn(8'h7F, 8'h00, 0, 1'b1);
    run_txn(8'h80, 8'hFF, 0, 1'b1);
    run_txn(8'h00, 8'h00, 0, 1'b1);
    // R9 start while busy
    run_txn(8'h85, 8'hA6, 1, 1'b0);
    run_txn(8'h05, 8'h00, 1, 1'b0);
    // R10 stuck line, then recovery
    run_txn(8'h02, 8'h00, 2, 1'b0);
    run_txn(8'h02, 8'h00, 0, 1'b1);
    // random mix over a small address range
    for (int n = 0; n < 36; n++) begin
      logic [7:0] rc, rw;
      rc = 8'($urandom_range(0, 255));
      rc[6:3] = 4'd0;
      rw = 8'($urandom_range(0, 255));
      run_txn(rc, rw, 0, (n % 4) == 0);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule